// File: doc/BRIEF.md
# Interrupt Entry Controller with Pre-Stacked Wait

This block performs the interrupt entry sequence for a small 8-bit processor with two accumulators (A, B), a 16-bit index register X, a 16-bit program counter and a condition-code byte. When an unmasked request arrives, or when the executor issues a software trap, it writes a seven-byte machine frame to a byte-wide stack port. It then sets the interrupt-mask bit in the condition code, reads a big-endian 16-bit vector through a byte-wide read port, and reports the new program counter together with the cycle cost of the entry.

Two low-power commands change how entry works. The wait command writes the frame at once and parks the controller, so a later interrupt skips the stacking and is charged a lower cost. The sleep command parks the controller without writing anything, and it wakes the same way. While the controller is busy or parked, `stall` holds instruction execution. Decoding and executing instructions is left to the surrounding core.

Top module: `ie_entry_ctrl`

## Requirements
- R1: After reset the controller is idle: `stall`, `waiting`, `sleeping`, `done`, `stk_we` and `vec_re` are all 0.
- R2: A stacked entry makes exactly 7 byte writes, one per cycle, at addresses SP, SP-1, ... SP-6, where SP is `sp_in` at acceptance. The bytes are, in order: PC low, PC high, X low, X high, A, B, CC. Afterwards `sp_out` equals SP-7.
- R3: The vector high byte is read at the vector address and the low byte at the vector address + 1. `pc_out` then holds {high, low}, and `done` is high for exactly one cycle.
- R4: On every entry, `cc_out` equals the CC captured at acceptance with bit 4 (the interrupt mask) forced to 1.
- R5: A stacked entry reports `cost` = 12, and `done` is seen 10 clock edges after the edge that accepts the request.
- R6: A request while idle with `cc_in` bit 4 = 1 is ignored: no stack write, no `done`, `stall` stays 0.
- R7: A one-cycle `swi_cmd` pulse stacks the same frame whatever the mask bit is, takes its vector from address 0xFFFA, and reports cost 12.
- R8: A `wait_cmd` pulse stacks the frame and then sets `waiting` and `stall`. A later unmasked request writes nothing more, clears `waiting`, reports cost 4, and gives `done` 3 edges after it is accepted.
- R9: While waiting, if the CC captured by the wait command has bit 4 = 1, a request does not release the stall and produces no `done`.
- R10: A `sleep_cmd` pulse sets `sleeping` and `stall` without any stack write. An unmasked request clears `sleeping`, makes no stack write, and reports cost 0.
- R11: When an unmasked request and a command arrive in the same idle cycle, the request wins and its vector address is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Level interrupt request |
| irq_vec | input | 16 | Address of the request's vector |
| swi_cmd | input | 1 | Software trap command pulse |
| wait_cmd | input | 1 | Wait command pulse |
| sleep_cmd | input | 1 | Sleep command pulse |
| pc_in | input | 16 | Current program counter |
| x_in | input | 16 | Current index register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| cc_in | input | 8 | Current condition code, bit 4 = mask |
| sp_in | input | 16 | Current stack pointer |
| stk_we | output | 1 | Stack byte write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 8 | Stack write byte |
| vec_re | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector read address |
| vec_rdata | input | 8 | Vector read byte, same cycle |
| stall | output | 1 | Hold instruction execution |
| waiting | output | 1 | Parked with frame already stacked |
| sleeping | output | 1 | Parked without frame |
| done | output | 1 | One-cycle pulse, new PC valid |
| pc_out | output | 16 | New program counter |
| cc_out | output | 8 | New condition code |
| sp_out | output | 16 | Stack pointer after entry |
| cost | output | 5 | Cycle cost of the entry |

## Verification
The hardest situation to reach is a wait that was stacked under a set mask and then receives requests it must refuse. Only one sequence gets there: drive a wait pulse with bit 4 of CC set, let the seven writes complete, then hold a request for many cycles while counting writes and `done` pulses, and finally use reset to leave. A second subtle case is the resume after an unmasked wait. Before raising the request, the bench changes every state input to new values, so any stray second push would show up both in the write count and in the stack contents. Random rounds then mix the four entry kinds with random register values, stack pointers and vector addresses.

// File: rtl/ie_pkg.sv
package ie_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 16;
  localparam int FRAME_BYTES = 7;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH, S_WAIT, S_SLEEP, S_VHI, S_VLO, S_FIN
  } st_t;

  typedef enum logic [1:0] {
    MODE_IDLE, MODE_WAIT, MODE_SLEEP, MODE_BUSY
  } mode_t;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_IRQ, ACT_SWI, ACT_WAIT, ACT_SLEEP, ACT_RES_W, ACT_RES_S
  } act_t;

  // byte k of the machine frame, k = 0 is written first
  function automatic logic [DATA_W-1:0] frame_byte(
    input logic [IDX_W-1:0]  k,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] x,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] cc);
    logic [DATA_W-1:0] r;
    case (k)
      3'd0:    r = pc[DATA_W-1:0];
      3'd1:    r = pc[ADDR_W-1:DATA_W];
      3'd2:    r = x[DATA_W-1:0];
      3'd3:    r = x[ADDR_W-1:DATA_W];
      3'd4:    r = a;
      3'd5:    r = b;
      default: r = cc;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] set_mask(
    input logic [DATA_W-1:0] cc, input int bitpos);
    logic [DATA_W-1:0] m;
    m = '0;
    m[bitpos] = 1'b1;
    return cc | m;
  endfunction
endpackage

// File: rtl/ie_arbiter.sv
module ie_arbiter
  import ie_pkg::*;
(
  input  mode_t mode,
  input  logic  irq_req,
  input  logic  live_mask,
  input  logic  held_mask,
  input  logic  swi_cmd,
  input  logic  wait_cmd,
  input  logic  sleep_cmd,
  output act_t  act
);
  logic irq_live_ok;
  logic irq_held_ok;

  assign irq_live_ok = irq_req && !live_mask;
  assign irq_held_ok = irq_req && !held_mask;

  always_comb begin
    act = ACT_NONE;
    unique case (mode)
      MODE_IDLE: begin
        if (irq_live_ok)    act = ACT_IRQ;
        else if (swi_cmd)   act = ACT_SWI;
        else if (wait_cmd)  act = ACT_WAIT;
        else if (sleep_cmd) act = ACT_SLEEP;
      end
      MODE_WAIT:  if (irq_held_ok) act = ACT_RES_W;
      MODE_SLEEP: if (irq_held_ok) act = ACT_RES_S;
      default:    act = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/ie_frame_mux.sv
module ie_frame_mux
  import ie_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] x,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] cc,
  output logic [DATA_W-1:0] byte_o
);
  assign byte_o = frame_byte(idx, pc, x, a, b, cc);
endmodule

// File: rtl/ie_entry_ctrl.sv
module ie_entry_ctrl
  import ie_pkg::*;
#(
  parameter int COST_W     = 5,
  parameter int COST_FULL  = 12,
  parameter int COST_WAIT  = 4,
  parameter int COST_SLEEP = 0,
  parameter int I_BIT      = 4,
  parameter logic [15:0] SWI_VEC = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] irq_vec,
  input  logic              swi_cmd,
  input  logic              wait_cmd,
  input  logic              sleep_cmd,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [DATA_W-1:0] cc_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              stk_we,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [DATA_W-1:0] stk_wdata,
  output logic              vec_re,
  output logic [ADDR_W-1:0] vec_addr,
  input  logic [DATA_W-1:0] vec_rdata,
  output logic              stall,
  output logic              waiting,
  output logic              sleeping,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] cc_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic [COST_W-1:0] cost
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  st_t               st;
  act_t              act;
  mode_t             mode;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] pc_r, x_r, sp_r, vec_r;
  logic [DATA_W-1:0] a_r, b_r, cc_r, hi_r;
  logic [COST_W-1:0] cost_r;
  logic              park_after;

  // named events for the checker
  logic take_stacked;
  logic take_resume;
  logic push_last;

  always_comb begin
    unique case (st)
      S_IDLE:  mode = MODE_IDLE;
      S_WAIT:  mode = MODE_WAIT;
      S_SLEEP: mode = MODE_SLEEP;
      default: mode = MODE_BUSY;
    endcase
  end

  ie_arbiter u_arb (
    .mode      (mode),
    .irq_req   (irq_req),
    .live_mask (cc_in[I_BIT]),
    .held_mask (cc_r[I_BIT]),
    .swi_cmd   (swi_cmd),
    .wait_cmd  (wait_cmd),
    .sleep_cmd (sleep_cmd),
    .act       (act)
  );

  ie_frame_mux u_mux (
    .idx    (idx),
    .pc     (pc_r),
    .x      (x_r),
    .a      (a_r),
    .b      (b_r),
    .cc     (cc_r),
    .byte_o (stk_wdata)
  );

  assign take_stacked = (act == ACT_IRQ) || (act == ACT_SWI) || (act == ACT_WAIT);
  assign take_resume  = (act == ACT_RES_W) || (act == ACT_RES_S);
  assign push_last    = (st == S_PUSH) && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      pc_r       <= '0;
      x_r        <= '0;
      a_r        <= '0;
      b_r        <= '0;
      cc_r       <= '0;
      sp_r       <= '0;
      vec_r      <= '0;
      hi_r       <= '0;
      cost_r     <= '0;
      park_after <= 1'b0;
      waiting    <= 1'b0;
      sleeping   <= 1'b0;
      pc_out     <= '0;
      cc_out     <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (take_stacked) begin
            pc_r       <= pc_in;
            x_r        <= x_in;
            a_r        <= a_in;
            b_r        <= b_in;
            cc_r       <= cc_in;
            sp_r       <= sp_in;
            idx        <= '0;
            park_after <= (act == ACT_WAIT);
            vec_r      <= (act == ACT_SWI) ? SWI_VEC : irq_vec;
            cost_r     <= COST_W'(COST_FULL);
            st         <= S_PUSH;
          end else if (act == ACT_SLEEP) begin
            cc_r     <= cc_in;
            sp_r     <= sp_in;
            sleeping <= 1'b1;
            st       <= S_SLEEP;
          end
        end
        S_PUSH: begin
          sp_r <= sp_r - 1'b1;
          idx  <= idx + 1'b1;
          if (push_last) begin
            if (park_after) begin
              waiting <= 1'b1;
              st      <= S_WAIT;
            end else begin
              st <= S_VHI;
            end
          end
        end
        S_WAIT, S_SLEEP: begin
          if (take_resume) begin
            waiting  <= 1'b0;
            sleeping <= 1'b0;
            vec_r    <= irq_vec;
            cost_r   <= (act == ACT_RES_W) ? COST_W'(COST_WAIT) : COST_W'(COST_SLEEP);
            st       <= S_VHI;
          end
        end
        S_VHI: begin
          hi_r <= vec_rdata;
          st   <= S_VLO;
        end
        S_VLO: begin
          pc_out <= {hi_r, vec_rdata};
          cc_out <= set_mask(cc_r, I_BIT);
          st     <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign stk_we   = (st == S_PUSH);
  assign stk_addr = sp_r;
  assign vec_re   = (st == S_VHI) || (st == S_VLO);
  assign vec_addr = (st == S_VLO) ? vec_r + 1'b1 : vec_r;
  assign stall    = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign sp_out   = sp_r;
  assign cost     = cost_r;
endmodule

// File: rtl/ie_entry_chk.sv
module ie_entry_chk #(
  parameter int COST_W     = 5,
  parameter int COST_FULL  = 12,
  parameter int COST_WAIT  = 4,
  parameter int COST_SLEEP = 0,
  parameter int I_BIT      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stk_we,
  input logic [15:0]       stk_addr,
  input logic              vec_re,
  input logic              stall,
  input logic              waiting,
  input logic              sleeping,
  input logic              done,
  input logic [7:0]        cc_out,
  input logic [COST_W-1:0] cost,
  input logic              take_resume
);
  // R2
  stack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we && $past(stk_we) |-> stk_addr == $past(stk_addr) - 16'd1);
  // R2
  port_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && vec_re));
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cc_out[I_BIT]);
  // R5
  cost_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cost == COST_W'(COST_FULL) || cost == COST_W'(COST_WAIT)
              || cost == COST_W'(COST_SLEEP)));
  // R8
  park_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(waiting && sleeping));
  // R8
  park_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting || sleeping) |-> stall);
  // R10
  resume_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_resume |=> !stk_we);
endmodule

bind ie_entry_ctrl ie_entry_chk #(
  .COST_W(COST_W), .COST_FULL(COST_FULL), .COST_WAIT(COST_WAIT),
  .COST_SLEEP(COST_SLEEP), .I_BIT(I_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stk_we(stk_we), .stk_addr(stk_addr),
  .vec_re(vec_re), .stall(stall), .waiting(waiting), .sleeping(sleeping),
  .done(done), .cc_out(cc_out), .cost(cost), .take_resume(take_resume)
);

// File: tb/sim_ie_entry_ctrl.sv
module sim_ie_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 0, swi_cmd = 0, wait_cmd = 0, sleep_cmd = 0;
  logic [15:0] irq_vec = 0, pc_in = 0, x_in = 0, sp_in = 0;
  logic [7:0]  a_in = 0, b_in = 0, cc_in = 0;
  logic stk_we, vec_re, stall, waiting, sleeping, done;
  logic [15:0] stk_addr, vec_addr, pc_out, sp_out;
  logic [7:0]  stk_wdata, vec_rdata, cc_out;
  logic [4:0]  cost;

  int total = 0, bad = 0, wr_cnt = 0, done_cnt = 0, cyc = 0;
  logic [7:0] smem [256];

  always #2 clk = ~clk;

  function automatic logic [7:0] vmem(input logic [15:0] ad);
    return ad[7:0] ^ {ad[11:8], ad[15:12]} ^ 8'hA5;
  endfunction

  assign vec_rdata = vmem(vec_addr);

  ie_entry_ctrl u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (stk_we) begin
      smem[stk_addr[7:0]] <= stk_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  always @(posedge clk) if (cyc > 150000) begin
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog: actual=%0d expected<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setstate(input logic [15:0] pc, x, sp, input logic [7:0] a, b, cc);
    pc_in = pc; x_in = x; sp_in = sp; a_in = a; b_in = b; cc_in = cc;
  endtask

  task automatic check_stack(input logic [15:0] pc, x, sp, input logic [7:0] a, b, cc, input string tag);
    logic [7:0] e [7];
    e = '{pc[7:0], pc[15:8], x[7:0], x[15:8], a, b, cc};
    for (int k = 0; k < 7; k++) begin
      logic [7:0] ad;
      ad = sp[7:0] - 8'(k);
      chk(smem[ad] === e[k], tag, smem[ad], e[k]);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!done && n < 60);
  endtask

  // kind: 0 irq, 1 swi, 2 wait then irq, 3 sleep then irq
  task automatic entry(input int kind, input logic [15:0] pc, x, sp, vec,
                       input logic [7:0] a, b, cc, input logic both);
    int n, w0;
    logic [15:0] ev;
    logic [7:0] ecc;
    @(negedge clk);
    w0 = wr_cnt;
    setstate(pc, x, sp, a, b, cc);
    irq_vec = vec;
    ev = (kind == 1) ? 16'hFFFA : vec;
    ecc = cc | 8'h10;
    if (kind == 0) begin
      irq_req = 1; swi_cmd = both;
      wait_done(n); swi_cmd = 0;
      chk(n == 10, "R5 latency", n, 10);
      chk(cost == 12, "R5 cost", cost, 12);
    end else if (kind == 1) begin
      swi_cmd = 1; @(posedge clk); @(negedge clk); swi_cmd = 0;
      wait_done(n);
      chk(cost == 12, "R7 cost", cost, 12);
      chk(pc_out == {vmem(16'hFFFA), vmem(16'hFFFB)}, "R7 vector", pc_out,
          {vmem(16'hFFFA), vmem(16'hFFFB)});
    end else if (kind == 2) begin
      wait_cmd = 1; @(posedge clk); @(negedge clk); wait_cmd = 0;
      repeat (10) @(negedge clk);
      chk(waiting && stall, "R8 parked", {waiting, stall}, 2'b11);
      chk(wr_cnt - w0 == 7, "R8 wait push", wr_cnt - w0, 7);
      check_stack(pc, x, sp, a, b, cc, "R8 wait frame");
      setstate(~pc, ~x, ~sp, ~a, ~b, cc);
      irq_req = 1;
      wait_done(n);
      chk(n == 3, "R8 resume latency", n, 3);
      chk(cost == 4, "R8 cost", cost, 4);
      chk(!waiting, "R8 cleared", waiting, 0);
      chk(wr_cnt - w0 == 7, "R8 no repush", wr_cnt - w0, 7);
    end else begin
      sleep_cmd = 1; @(posedge clk); @(negedge clk); sleep_cmd = 0;
      repeat (3) @(negedge clk);
      chk(sleeping && stall, "R10 parked", {sleeping, stall}, 2'b11);
      irq_req = 1;
      wait_done(n);
      chk(cost == 0, "R10 cost", cost, 0);
      chk(!sleeping, "R10 cleared", sleeping, 0);
      chk(wr_cnt == w0, "R10 no push", wr_cnt - w0, 0);
    end
    chk(done, "R3 done seen", done, 1);
    chk(pc_out == {vmem(ev), vmem(ev + 16'd1)}, "R3 pc", pc_out, {vmem(ev), vmem(ev + 16'd1)});
    chk(cc_out == ecc, "R4 cc", cc_out, ecc);
    if (kind < 3) begin
      chk(sp_out == sp - 16'd7, "R2 sp", sp_out, sp - 16'd7);
      if (kind != 2) check_stack(pc, x, sp, a, b, cc, "R2 frame");
    end
    irq_req = 0;
    @(negedge clk);
    chk(!done, "R3 one-cycle", done, 0);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; irq_req = 0; swi_cmd = 0; wait_cmd = 0; sleep_cmd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({stall, waiting, sleeping, done, stk_we, vec_re} == 6'b0, "R1 reset",
        {stall, waiting, sleeping, done, stk_we, vec_re}, 0);
  endtask

  initial begin
    int w0, d0;
    void'($urandom(32'd4417));
    do_reset();

    entry(0, 16'h1234, 16'hBEEF, 16'h00F0, 16'h8000, 8'h11, 8'h22, 8'h03, 0);

    // R6 masked request while idle
    @(negedge clk);
    w0 = wr_cnt; d0 = done_cnt;
    cc_in = 8'h10; irq_req = 1;
    repeat (15) @(negedge clk);
    chk(wr_cnt == w0 && done_cnt == d0, "R6 masked ignored", wr_cnt - w0 + done_cnt - d0, 0);
    chk(!stall, "R6 no stall", stall, 0);
    irq_req = 0;

    entry(1, 16'hCAFE, 16'h0102, 16'h0080, 16'h0000, 8'h5A, 8'hA5, 8'h10, 0);
    entry(2, 16'h4000, 16'h7777, 16'h01FF, 16'hFFF8, 8'h01, 8'h02, 8'h00, 0);
    entry(3, 16'h2222, 16'h3333, 16'h0050, 16'h1FF0, 8'h09, 8'h08, 8'h81, 0);
    // R11 request beats a trap in the same cycle
    entry(0, 16'h0F0F, 16'hF0F0, 16'h00A0, 16'h3456, 8'h44, 8'h55, 8'h00, 1);

    // R9 wait under a set mask never releases
    @(negedge clk);
    w0 = wr_cnt; d0 = done_cnt;
    setstate(16'h5555, 16'h6666, 16'h00C0, 8'h12, 8'h34, 8'h10);
    wait_cmd = 1; @(negedge clk); wait_cmd = 0;
    cc_in = 8'h00; irq_req = 1;
    repeat (20) @(negedge clk);
    chk(waiting && stall, "R9 still parked", {waiting, stall}, 2'b11);
    chk(done_cnt == d0, "R9 no done", done_cnt - d0, 0);
    chk(wr_cnt - w0 == 7, "R9 only wait push", wr_cnt - w0, 7);
    do_reset();

    for (int i = 0; i < 24; i++) begin
      int kind;
      logic [7:0] cc;
      kind = int'($urandom_range(0, 3));
      cc = 8'($urandom) & 8'hEF;
      if (kind == 1) cc[4] = 1'($urandom);
      entry(kind, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            8'($urandom), 8'($urandom), cc, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule